// File: doc/BRIEF.md
# Capture Timer with Two-Event Edge Timestamping

This block is a free-running up-counter with a small register port and an input-capture unit. The unit stamps transitions on an external pin with the counter value. Software stops the counter, clears it through the counter register and picks an edge mode and an event count in the control word. It then restarts the counter, waits, and reads two capture registers. The difference between the second and the first capture is the signal's period in clocks when rising edges are captured, or its high time when both edges are captured.

The pin passes through a synchroniser, and edges are detected on the synchronised level. In two-event mode the first qualifying edge fills capture slot A and the second fills slot B. The unit then stays frozen until software acknowledges it. In single-event mode every qualifying edge overwrites slot A. The counter either wraps to zero on overflow or reloads from a load register.

Top module: `capture_timer`

## Requirements
- R1: After reset, the control, counter, load, capture A, capture B and status registers all read 0.
- R2: While control bit 0 (run) is 1, the counter goes up by one every clock. While it is 0, the counter holds its value.
- R3: A write to the counter register (address 1) loads the written value on that clock edge and takes priority over counting.
- R4: When the counter is running and at its maximum value, the next clock sets it to 0 if control bit 1 (reload) is 0. If bit 1 is 1, the next clock sets it to the load register value (address 2).
- R5: Capture is active only when control bit 14 (pin is capture input) is 1. Control bits 9:8 choose the qualifying edge: 00 none, 01 rising, 10 falling, 11 both. With no qualifying edge, the capture registers do not change.
- R6: A pin change that is first sampled at clock edge t stores the counter value held after edge t+1. That value can be read after edge t+2.
- R7: With control bit 13 (two-event) set, the first qualifying edge writes capture A (address 3) and sets status bit 1. The second edge writes capture B (address 4) and sets status bit 0 (done). The status register is at address 5.
- R8: Once done is set, further edges change neither capture register. Writing 1 to status bit 0, or any write to the control register, clears both status bits and rearms the unit.
- R9: With control bit 13 clear, each qualifying edge overwrites capture A. Capture B and the done bit stay unchanged.
- R10: Writing control value 0x0001 keeps the counter running and disables capture.
- R11: When the counter runs undisturbed, capture B minus capture A (modulo 2^CNT_W) equals the period in clocks in rising mode, the low-to-low period in falling mode, and the high time in both-edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register select: 0 control, 1 counter, 2 load, 3 capture A, 4 capture B, 5 status |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the selected register, combinational |
| cap_pin | input | 1 | Asynchronous capture input |

## Verification
Register writes take effect on the edge that samples the strobe, and reads are combinational. The bench therefore drives at falling edges and reads one time step later. A pin change made at a falling edge is latched three rising edges later. The latched value is the counter value after the second of those edges. The one absolute timestamp check counts edges from a counter clear to that point. All period and high-time checks compare capture differences with the number of falling edges between pin changes, so they do not depend on that fixed offset. Each check waits at least five cycles after the last pin change before it reads.

// File: rtl/capture_timer_pkg.sv
`timescale 1ns/1ps
package capture_timer_pkg;
   localparam int unsigned CTL_RUN     = 0;
   localparam int unsigned CTL_RELOAD  = 1;
   localparam int unsigned CTL_SEL_LO  = 8;
   localparam int unsigned CTL_TWO     = 13;
   localparam int unsigned CTL_PIN_IN  = 14;
   localparam int unsigned CTL_BITS    = 16;

   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_COUNT = 3'd1;
   localparam logic [2:0] A_LOAD  = 3'd2;
   localparam logic [2:0] A_CAPA  = 3'd3;
   localparam logic [2:0] A_CAPB  = 3'd4;
   localparam logic [2:0] A_STAT  = 3'd5;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/ct_edge_sync.sv
`timescale 1ns/1ps
module ct_edge_sync
   import capture_timer_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  edge_sel_e sel,
   output logic      hit
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ct_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              rise, fall;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= pin;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];

   assign rise = chain_q[STAGES-1] & ~prev_q;
   assign fall = ~chain_q[STAGES-1] & prev_q;

   always_comb begin
      unique case (sel)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/ct_counter.sv
`timescale 1ns/1ps
module ct_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             reload_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt;
      if (wr_en)              cnt_d = wr_val;
      else if (run) begin
         if (cnt == CNT_MAX)  cnt_d = reload_en ? load_val : '0;
         else                 cnt_d = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
endmodule

// File: rtl/ct_capture.sv
`timescale 1ns/1ps
module ct_capture #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             two_mode,
   input  logic             hit,
   input  logic             rearm,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap_a,
   output logic [CNT_W-1:0] cap_b,
   output logic             first,
   output logic             done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_a <= '0;
         cap_b <= '0;
         first <= 1'b0;
         done  <= 1'b0;
      end else if (rearm) begin
         first <= 1'b0;
         done  <= 1'b0;
      end else if (enable && hit) begin
         if (!two_mode) begin
            cap_a <= cnt;
         end else if (!first) begin
            cap_a <= cnt;
            first <= 1'b1;
         end else if (!done) begin
            cap_b <= cnt;
            done  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/capture_timer.sv
`timescale 1ns/1ps
module capture_timer
   import capture_timer_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              cap_pin
);
   if (CNT_W < CTL_BITS) begin : g_bad_width
      $error("capture_timer: CNT_W must hold the control word");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("capture_timer: ADDR_W must be at least 3");
   end

   logic [CTL_BITS-1:0] ctrl_q;
   logic [CNT_W-1:0]    load_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [CNT_W-1:0]    cap_a_q, cap_b_q;
   logic                first_q, done_q;
   logic                edge_hit;
   logic                wr_ctrl, wr_cnt, wr_load, wr_stat;
   logic                rearm;
   logic [2:0]          sel_addr;
   logic                addr_hi_zero;

   assign sel_addr     = bus_addr[2:0];
   if (ADDR_W > 3) begin : g_addr_hi
      assign addr_hi_zero = (bus_addr[ADDR_W-1:3] == '0);
   end else begin : g_addr_exact
      assign addr_hi_zero = 1'b1;
   end

   assign wr_ctrl = bus_wr && addr_hi_zero && (sel_addr == A_CTRL);
   assign wr_cnt  = bus_wr && addr_hi_zero && (sel_addr == A_COUNT);
   assign wr_load = bus_wr && addr_hi_zero && (sel_addr == A_LOAD);
   assign wr_stat = bus_wr && addr_hi_zero && (sel_addr == A_STAT);
   assign rearm   = wr_ctrl || (wr_stat && bus_wdata[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata[CTL_BITS-1:0];
         if (wr_load) load_q <= bus_wdata;
      end
   end

   ct_counter #(.CNT_W(CNT_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ctrl_q[CTL_RUN]),
      .reload_en (ctrl_q[CTL_RELOAD]),
      .load_val  (load_q),
      .wr_en     (wr_cnt),
      .wr_val    (bus_wdata),
      .cnt       (cnt_q)
   );

   ct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cap_pin),
      .sel   (edge_sel_e'(ctrl_q[CTL_SEL_LO+1:CTL_SEL_LO])),
      .hit   (edge_hit)
   );

   ct_capture #(.CNT_W(CNT_W)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctrl_q[CTL_PIN_IN]),
      .two_mode (ctrl_q[CTL_TWO]),
      .hit      (edge_hit),
      .rearm    (rearm),
      .cnt      (cnt_q),
      .cap_a    (cap_a_q),
      .cap_b    (cap_b_q),
      .first    (first_q),
      .done     (done_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (addr_hi_zero) begin
         unique case (sel_addr)
            A_CTRL:  bus_rdata = CNT_W'(ctrl_q);
            A_COUNT: bus_rdata = cnt_q;
            A_LOAD:  bus_rdata = load_q;
            A_CAPA:  bus_rdata = cap_a_q;
            A_CAPB:  bus_rdata = cap_b_q;
            A_STAT:  bus_rdata = CNT_W'({first_q, done_q});
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/capture_timer_chk.sv
`timescale 1ns/1ps
module capture_timer_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] wdata,
   input logic             run,
   input logic             reload_en,
   input logic [CNT_W-1:0] load_val,
   input logic [CNT_W-1:0] cap_a,
   input logic [CNT_W-1:0] cap_b,
   input logic             first,
   input logic             done,
   input logic             cap_en,
   input logic             two_mode,
   input logic             rearm
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cnt_wr && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1); // R2
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt)); // R2
   AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt == $past(wdata)); // R3
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cnt_wr && cnt == MAXV && !reload_en) |=> cnt == '0); // R4
   AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cnt_wr && cnt == MAXV && reload_en) |=> cnt == $past(load_val)); // R4
   AST_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> ($stable(cap_a) && $stable(cap_b))); // R5
   AST_DONE_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> first); // R7
   AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rearm) |=> ($stable(cap_a) && $stable(cap_b) && done)); // R8
   AST_SINGLE_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
      !two_mode |=> $stable(cap_b)); // R9
endmodule

bind capture_timer capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt       (cnt_q),
   .cnt_wr    (wr_cnt),
   .wdata     (bus_wdata),
   .run       (ctrl_q[0]),
   .reload_en (ctrl_q[1]),
   .load_val  (load_q),
   .cap_a     (cap_a_q),
   .cap_b     (cap_b_q),
   .first     (first_q),
   .done      (done_q),
   .cap_en    (ctrl_q[14]),
   .two_mode  (ctrl_q[13]),
   .rearm     (rearm)
);

// File: tb/capture_timer_test.sv
`timescale 1ns/1ps
module capture_timer_test;
   localparam int W = 32;
   localparam logic [2:0] RA_CTRL = 3'd0, RA_CNT = 3'd1, RA_LOAD = 3'd2,
                          RA_CAPA = 3'd3, RA_CAPB = 3'd4, RA_STAT = 3'd5;
   localparam logic [W-1:0] C_PERIOD = 32'h6101, C_HIGH = 32'h6301,
                            C_FALL = 32'h6201, C_SINGLE = 32'h4101,
                            C_NOSEL = 32'h6001, C_NOPIN = 32'h2101;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic          cap_pin = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   capture_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin)
   );

   function automatic logic [W-1:0] span(input logic [W-1:0] a, input logic [W-1:0] b);
      return b - a;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(input logic [W-1:0] mode, input int first_len, input int second_len,
                          input logic start_level, output logic [W-1:0] diff);
      logic [W-1:0] a, b;
      cap_pin = start_level;
      cyc(6);
      wr(RA_CTRL, mode);
      cyc(2);
      cap_pin = ~start_level;
      cyc(first_len);
      cap_pin = start_level;
      cyc(second_len);
      cap_pin = ~start_level;
      cyc(6);
      rd(RA_CAPA, a);
      rd(RA_CAPB, b);
      diff = span(a, b);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] v, v2, a0, b0, d;
      void'($urandom(32'hC0FFEE));
      cyc(3);
      rst_n = 1'b1;
      cyc(2);

      rd(RA_CTRL, v); check("R1 ctrl", v, 0);
      rd(RA_CNT, v);  check("R1 count", v, 0);
      rd(RA_LOAD, v); check("R1 load", v, 0);
      rd(RA_CAPA, v); check("R1 capA", v, 0);
      rd(RA_CAPB, v); check("R1 capB", v, 0);
      rd(RA_STAT, v); check("R1 status", v, 0);

      cyc(5);
      rd(RA_CNT, v); check("R2 hold when stopped", v, 0);
      wr(RA_CNT, 32'd12345);
      rd(RA_CNT, v); check("R3 counter write", v, 32'd12345);

      wr(RA_CTRL, 32'h1);
      rd(RA_CNT, v);
      cyc(17);
      rd(RA_CNT, v2); check("R2 counting", span(v, v2), 17);

      wr(RA_CNT, 32'hFFFF_FFFE);
      cyc(2);
      rd(RA_CNT, v); check("R4 wrap to zero", v, 0);
      wr(RA_LOAD, 32'd100);
      wr(RA_CTRL, 32'h3);
      wr(RA_CNT, 32'hFFFF_FFFF);
      cyc(1);
      rd(RA_CNT, v); check("R4 reload on overflow", v, 32'd100);

      // R6: absolute timestamp after clearing the counter
      wr(RA_CTRL, C_PERIOD);
      wr(RA_CNT, 0);
      cyc(7);
      cap_pin = 1'b1;
      cyc(6);
      rd(RA_CAPA, v); check("R6 timestamp latency", v, 9);
      rd(RA_STAT, v); check("R7 first flag only", v, 32'h2);
      cap_pin = 1'b0;
      cyc(6);

      // R7/R11 random periods in rising mode
      for (int i = 0; i < 5; i++) begin
         int h, l;
         h = 2 + int'($urandom % 30);
         l = 2 + int'($urandom % 30);
         measure(C_PERIOD, h, l, 1'b0, d);
         check("R11 rising period", d, W'(h + l));
         rd(RA_STAT, v); check("R7 done after two edges", v, 32'h3);
         cap_pin = 1'b0;
         cyc(4);
      end

      // R8: frozen after done, then acknowledge
      rd(RA_CAPA, a0); rd(RA_CAPB, b0);
      for (int i = 0; i < 3; i++) begin
         cap_pin = 1'b1; cyc(3); cap_pin = 1'b0; cyc(3);
      end
      cyc(4);
      rd(RA_CAPA, v); check("R8 capA frozen", v, a0);
      rd(RA_CAPB, v); check("R8 capB frozen", v, b0);
      wr(RA_STAT, 32'h1);
      rd(RA_STAT, v); check("R8 acknowledge clears status", v, 0);
      cap_pin = 1'b1; cyc(11); cap_pin = 1'b0; cyc(4); cap_pin = 1'b1; cyc(6);
      rd(RA_CAPA, v); rd(RA_CAPB, v2);
      check("R8 rearmed capture", span(v, v2), 15);
      cap_pin = 1'b0; cyc(6);

      // R11 high time, both edges
      for (int i = 0; i < 5; i++) begin
         int h, l;
         h = 2 + int'($urandom % 40);
         l = 2 + int'($urandom % 10);
         measure(C_HIGH, h, l, 1'b0, d);
         check("R11 high time", d, W'(h));
         cap_pin = 1'b0; cyc(4);
      end

      // R5 falling mode: fall-to-fall
      for (int i = 0; i < 3; i++) begin
         int h, l;
         h = 2 + int'($urandom % 20);
         l = 2 + int'($urandom % 20);
         measure(C_FALL, h, l, 1'b1, d);
         check("R5 falling period", d, W'(h + l));
         cap_pin = 1'b1; cyc(4);
      end
      cap_pin = 1'b0; cyc(6);

      // R9 single-event mode
      rd(RA_CAPB, b0);
      wr(RA_CTRL, C_SINGLE);
      cap_pin = 1'b1; cyc(6);
      rd(RA_CAPA, a0);
      cap_pin = 1'b0; cyc(9); cap_pin = 1'b1; cyc(6);
      rd(RA_CAPA, v); check("R9 capA overwritten", span(a0, v), 15);
      rd(RA_CAPB, v); check("R9 capB unchanged", v, b0);
      rd(RA_STAT, v); check("R9 no done", v, 0);
      cap_pin = 1'b0; cyc(6);

      // R5 no edge select / pin not input; R10 clear to run-only
      foreach (a0[k]) begin end
      rd(RA_CAPA, a0); rd(RA_CAPB, b0);
      wr(RA_CTRL, C_NOSEL);
      cap_pin = 1'b1; cyc(5); cap_pin = 1'b0; cyc(5);
      rd(RA_CAPA, v); check("R5 sel 00 ignores edges", v, a0);
      wr(RA_CTRL, C_NOPIN);
      cap_pin = 1'b1; cyc(5); cap_pin = 1'b0; cyc(5);
      rd(RA_CAPA, v); check("R5 bit14 clear ignores edges", v, a0);
      rd(RA_CAPB, v); check("R5 capB untouched", v, b0);
      wr(RA_CTRL, 32'h1);
      rd(RA_CNT, v);
      cap_pin = 1'b1; cyc(5); cap_pin = 1'b0; cyc(5);
      rd(RA_CNT, v2); check("R10 counter keeps running", span(v, v2), 10);
      rd(RA_CAPA, v); check("R10 capture disabled", v, a0);
      rd(RA_CTRL, v); check("R10 control readback", v, 32'h1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule